// File: doc/BRIEF.md
# Two-Level Shared Interrupt Aggregator

This block gathers single-cycle event pulses from a storage-card host function into a local status register. Each local status bit has a matching enable bit. The enabled, pending local bits are ORed into one summary. That summary becomes bit 0 of a global status register. Bit 1 of the same global register belongs to a second peripheral function, which presents its own event pulse.

The global level has two independent masks:
- a status-enable mask, which decides whether a source is recorded at all;
- a signal-enable mask, which decides whether a recorded bit drives the single registered interrupt line.

Software reaches every register through a simple word port. Both status levels are cleared by writing ones.

A typical handler works in three steps. It reads the global register to find which function raised the line. It reads and clears the local status bits it has serviced. It then clears the global bit. If an enabled local bit is still pending, the global bit is raised again.

Top module: `intr_cascade`

## Requirements
- R1: After a synchronous reset, every status and enable register reads zero, `irq` is low and `reg_rdata` is zero.
- R2: A pulse on `card_evt[i]` sets local status bit i on the next clock edge, whether or not bit i is enabled. The implemented bits are: card detect 0, status change 1, memory mode 2, I/O mode 3, IDE mode 8, PIO transfer error 9, buffer available 10 and transfer done 11. Pulses on bits 4 to 7 are ignored, and those bits read zero.
- R3: A write to address 0 clears each local status bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set. This holds at both levels.
- R5: Global bit 0 sets on the clock edge after some local bit is both set and enabled, provided global status-enable bit 0 is 1. Pending local bits that are not enabled never set it.
- R6: A pulse on `peer_evt` sets global bit 1 on the next edge only if global status-enable bit 1 is 1. Otherwise the pulse is lost.
- R7: A write to address 2 clears global status bits written with 1. If the source of such a bit is still active in that cycle, the bit stays set.
- R8: `irq` is a register. It equals the OR over global bits that are set, status-enabled and signal-enabled, one cycle later.
- R9: The address map is:

  | Address | Register |
  |---|---|
  | 0 | local status |
  | 1 | local enable |
  | 2 | global status |
  | 3 | global status-enable |
  | 4 | global signal-enable |

  `reg_rdata` shows the register selected by `reg_addr` one cycle after `reg_addr` is presented. Unused addresses read zero, and reads have no side effects.
- R10: The enable registers keep only implemented bits. Local enable holds bits 0 to 3 and 8 to 11. Both global masks hold bits 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_evt | input | 12 | Event pulses from the card-host function |
| peer_evt | input | 1 | Event pulse from the second peripheral function |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| irq | output | 1 | Registered shared interrupt line |

## Verification
The bench targets several cases where a wrong design gives a visibly wrong result:
- **Event and clear in the same cycle.** A design that lets the clear win loses the event, so the bit reads zero.
- **Clearing a global bit while an enabled local bit is still pending.** A design that clears unconditionally drops the summary. The line then stays quiet although work remains.
- **The two global masks.** A design that confuses them either records peer events that should be lost, or raises `irq` for a recorded bit whose signal mask is zero.
- **Reserved local positions and writes of zero.** If these set bits or clear bits, the wrong values show up on read-back.

A long random stretch then compares every output against a behavioural model on every cycle.

// File: rtl/intr_cascade_pkg.sv
package intr_cascade_pkg;
  // register addresses
  localparam int unsigned IC_A_LSTS = 0;
  localparam int unsigned IC_A_LEN  = 1;
  localparam int unsigned IC_A_GSTS = 2;
  localparam int unsigned IC_A_GSE  = 3;
  localparam int unsigned IC_A_GSIG = 4;

  // global bit owners
  localparam int unsigned IC_G_CARD = 0;
  localparam int unsigned IC_G_PEER = 1;
  localparam int unsigned IC_GLB_W  = 2;

  typedef struct packed {
    logic lsts_clr;
    logic len_ld;
    logic gsts_clr;
    logic gse_ld;
    logic gsig_ld;
  } ic_wr_sel_t;
endpackage

// File: rtl/ic_sticky_cell.sv
module ic_sticky_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk) begin
    if (rst)        q_q <= 1'b0;
    else if (set_i) q_q <= 1'b1;
    else if (clr_i) q_q <= 1'b0;
  end

  assign q_o = q_q;

  // R4: a set in the same cycle as a clear leaves the bit high
  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o);

  // R3: with neither set nor clear the bit keeps its value
  p_hold_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(q_o));
endmodule

// File: rtl/ic_local_bank.sv
module ic_local_bank #(
  parameter int unsigned LW    = 12,
  parameter logic [LW-1:0] VALID = 12'hF0F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] evt_i,
  input  logic [LW-1:0] clr_i,
  input  logic          en_ld_i,
  input  logic [LW-1:0] en_wdata_i,
  output logic [LW-1:0] sts_o,
  output logic [LW-1:0] en_o,
  output logic          summary_o
);
  logic [LW-1:0] sts;
  logic [LW-1:0] en_q;

  for (genvar i = 0; i < LW; i++) begin : g_bit
    if (VALID[i]) begin : g_impl
      ic_sticky_cell u_cell (
        .clk   (clk),
        .rst   (rst),
        .set_i (evt_i[i]),
        .clr_i (clr_i[i]),
        .q_o   (sts[i])
      );
    end else begin : g_rsvd
      assign sts[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          en_q <= '0;
    else if (en_ld_i) en_q <= en_wdata_i & VALID;
  end

  assign sts_o     = sts;
  assign en_o      = en_q;
  assign summary_o = |(sts & en_q);

  // R2: every implemented event pulse is visible in status next cycle
  p_evt_latch_r2: assert property (@(posedge clk) disable iff (rst)
    |(evt_i & VALID) |=> ((sts_o & $past(evt_i & VALID)) == $past(evt_i & VALID)));
endmodule

// File: rtl/ic_global_bank.sv
module ic_global_bank #(
  parameter int unsigned GW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [GW-1:0] src_i,
  input  logic [GW-1:0] clr_i,
  input  logic          gse_ld_i,
  input  logic          gsig_ld_i,
  input  logic [GW-1:0] wdata_i,
  output logic [GW-1:0] sts_o,
  output logic [GW-1:0] gse_o,
  output logic [GW-1:0] gsig_o,
  output logic          irq_o
);
  logic [GW-1:0] sts;
  logic [GW-1:0] gse_q;
  logic [GW-1:0] gsig_q;
  logic [GW-1:0] rec;
  logic          irq_q;

  assign rec = src_i & gse_q;

  for (genvar g = 0; g < GW; g++) begin : g_glb
    ic_sticky_cell u_cell (
      .clk   (clk),
      .rst   (rst),
      .set_i (rec[g]),
      .clr_i (clr_i[g]),
      .q_o   (sts[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gse_q  <= '0;
      gsig_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (gse_ld_i)  gse_q  <= wdata_i;
      if (gsig_ld_i) gsig_q <= wdata_i;
      irq_q <= |(sts & gse_q & gsig_q);
    end
  end

  assign sts_o  = sts;
  assign gse_o  = gse_q;
  assign gsig_o = gsig_q;
  assign irq_o  = irq_q;

  // R5/R6: a global bit only rises when its source was active and status-enabled
  p_rise_gated_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((sts_o & ~$past(sts_o)) & ~$past(src_i & gse_o)) == '0));

  // R8: line follows the masked OR one cycle later
  p_irq_follow_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|(sts_o & gse_o & gsig_o))));
endmodule

// File: rtl/ic_regdec.sv
module ic_regdec
  import intr_cascade_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] lsts_i,
  input  logic [DATA_W-1:0] len_i,
  input  logic [DATA_W-1:0] gsts_i,
  input  logic [DATA_W-1:0] gse_i,
  input  logic [DATA_W-1:0] gsig_i,
  output ic_wr_sel_t        sel_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    sel_o          = '0;
    sel_o.lsts_clr = wr_i && (addr_i == ADDR_W'(IC_A_LSTS));
    sel_o.len_ld   = wr_i && (addr_i == ADDR_W'(IC_A_LEN));
    sel_o.gsts_clr = wr_i && (addr_i == ADDR_W'(IC_A_GSTS));
    sel_o.gse_ld   = wr_i && (addr_i == ADDR_W'(IC_A_GSE));
    sel_o.gsig_ld  = wr_i && (addr_i == ADDR_W'(IC_A_GSIG));
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(IC_A_LSTS): rd_mux = lsts_i;
      ADDR_W'(IC_A_LEN):  rd_mux = len_i;
      ADDR_W'(IC_A_GSTS): rd_mux = gsts_i;
      ADDR_W'(IC_A_GSE):  rd_mux = gse_i;
      ADDR_W'(IC_A_GSIG): rd_mux = gsig_i;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;

  // R9: at most one register is targeted by a write
  p_one_target_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sel_o.lsts_clr, sel_o.len_ld, sel_o.gsts_clr, sel_o.gse_ld, sel_o.gsig_ld}));
endmodule

// File: rtl/intr_cascade.sv
module intr_cascade
  import intr_cascade_pkg::*;
#(
  parameter int unsigned   LOCAL_W     = 12,
  parameter logic [11:0]   LOCAL_VALID = 12'hF0F,
  parameter int unsigned   ADDR_W      = 3,
  parameter int unsigned   DATA_W      = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LOCAL_W-1:0] card_evt,
  input  logic               peer_evt,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq
);
  localparam int unsigned GW    = IC_GLB_W;
  localparam int unsigned LPAD  = DATA_W - LOCAL_W;
  localparam int unsigned GPAD  = DATA_W - GW;

  ic_wr_sel_t          sel;
  logic [LOCAL_W-1:0]  lsts;
  logic [LOCAL_W-1:0]  len;
  logic                card_sum;
  logic [GW-1:0]       gsrc;
  logic [GW-1:0]       gsts;
  logic [GW-1:0]       gse;
  logic [GW-1:0]       gsig;
  logic [LOCAL_W-1:0]  lclr;
  logic [GW-1:0]       gclr;

  assign lclr = sel.lsts_clr ? reg_wdata[LOCAL_W-1:0] : '0;
  assign gclr = sel.gsts_clr ? reg_wdata[GW-1:0] : '0;

  assign gsrc[IC_G_CARD] = card_sum;
  assign gsrc[IC_G_PEER] = peer_evt;

  ic_local_bank #(
    .LW    (LOCAL_W),
    .VALID (LOCAL_VALID[LOCAL_W-1:0])
  ) u_local (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (card_evt),
    .clr_i      (lclr),
    .en_ld_i    (sel.len_ld),
    .en_wdata_i (reg_wdata[LOCAL_W-1:0]),
    .sts_o      (lsts),
    .en_o       (len),
    .summary_o  (card_sum)
  );

  ic_global_bank #(
    .GW (GW)
  ) u_global (
    .clk       (clk),
    .rst       (rst),
    .src_i     (gsrc),
    .clr_i     (gclr),
    .gse_ld_i  (sel.gse_ld),
    .gsig_ld_i (sel.gsig_ld),
    .wdata_i   (reg_wdata[GW-1:0]),
    .sts_o     (gsts),
    .gse_o     (gse),
    .gsig_o    (gsig),
    .irq_o     (irq)
  );

  ic_regdec #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regdec (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (reg_wr),
    .addr_i  (reg_addr),
    .lsts_i  ({{LPAD{1'b0}}, lsts}),
    .len_i   ({{LPAD{1'b0}}, len}),
    .gsts_i  ({{GPAD{1'b0}}, gsts}),
    .gse_i   ({{GPAD{1'b0}}, gse}),
    .gsig_i  ({{GPAD{1'b0}}, gsig}),
    .sel_o   (sel),
    .rdata_o (reg_rdata)
  );

  // R5: summary into global bit 0 needs an enabled pending local bit
  p_card_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (gsts[IC_G_CARD] && !$past(gsts[IC_G_CARD])) |-> $past(|(lsts & len)));
endmodule

// File: tb/intr_cascade_tb.sv
module intr_cascade_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] card_evt = '0;
  logic        peer_evt = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #4 clk = ~clk;

  intr_cascade u_dut (
    .clk       (clk),
    .rst       (rst),
    .card_evt  (card_evt),
    .peer_evt  (peer_evt),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  // behavioural reference
  logic [11:0] m_lsts, m_len;
  logic [1:0]  m_gsts, m_gse, m_gsig;
  logic [15:0] m_rd;
  logic        m_irq;

  always @(posedge clk) begin
    logic [11:0] lclr;
    logic [1:0]  gclr, gsrc;
    logic [15:0] rd;
    logic        nirq;
    if (rst) begin
      m_lsts = 0; m_len = 0; m_gsts = 0; m_gse = 0; m_gsig = 0; m_rd = 0; m_irq = 0;
    end else begin
      case (reg_addr)
        3'd0: rd = {4'h0, m_lsts};
        3'd1: rd = {4'h0, m_len};
        3'd2: rd = {14'h0, m_gsts};
        3'd3: rd = {14'h0, m_gse};
        3'd4: rd = {14'h0, m_gsig};
        default: rd = 16'h0;
      endcase
      lclr = (reg_wr && reg_addr == 3'd0) ? reg_wdata[11:0] : 12'h0;
      gclr = (reg_wr && reg_addr == 3'd2) ? reg_wdata[1:0] : 2'h0;
      gsrc = {peer_evt, (m_lsts & m_len) != 0};
      nirq = (m_gsts & m_gse & m_gsig) != 0;
      m_lsts = ((m_lsts & ~lclr) | card_evt) & 12'hF0F;
      m_gsts = (m_gsts & ~gclr) | (gsrc & m_gse);
      if (reg_wr && reg_addr == 3'd1) m_len  = reg_wdata[11:0] & 12'hF0F;
      if (reg_wr && reg_addr == 3'd3) m_gse  = reg_wdata[1:0];
      if (reg_wr && reg_addr == 3'd4) m_gsig = reg_wdata[1:0];
      m_irq = nirq;
      m_rd  = rd;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // cycle compare against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(cur_req, reg_rdata, m_rd);
      chk(cur_req, {15'h0, irq}, {15'h0, m_irq});
    end
  end

  task automatic drive(input logic [11:0] ev, input logic pe, input logic w,
                       input logic [2:0] a, input logic [15:0] d);
    card_evt = ev; peer_evt = pe; reg_wr = w; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    card_evt = '0; peer_evt = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    drive('0, 1'b0, 1'b1, a, d);
  endtask

  task automatic peek(input string req, input logic [2:0] a, input logic [15:0] exp);
    reg_addr = a;
    @(negedge clk);
    chk(req, reg_rdata, exp);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #1_600_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(5);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R1";
    chk("R1", reg_rdata, 16'h0);
    chk("R1", {15'h0, irq}, 16'h0);
    for (int a = 0; a < 5; a++) peek("R1", 3'(a), 16'h0);

    // R2: each position pulsed with no enables
    cur_req = "R2";
    for (int b = 0; b < 12; b++) drive(12'(1 << b), 1'b0, 1'b0, 3'd0, 16'h0);
    peek("R2", 3'd0, 16'h0F0F);
    peek("R2", 3'd2, 16'h0000);

    // R3: write-one-to-clear on local status
    cur_req = "R3";
    wreg(3'd0, 16'h0000);
    peek("R3", 3'd0, 16'h0F0F);
    wreg(3'd0, 16'h0003);
    peek("R3", 3'd0, 16'h0F0C);
    wreg(3'd0, 16'hFFFF);
    peek("R3", 3'd0, 16'h0000);

    // R10: enable masks keep implemented bits
    cur_req = "R10";
    wreg(3'd1, 16'hFFFF);
    peek("R10", 3'd1, 16'h0F0F);
    wreg(3'd3, 16'hFFFF);
    peek("R10", 3'd3, 16'h0003);
    wreg(3'd4, 16'hFFFC);
    peek("R10", 3'd4, 16'h0000);

    // R5: summary gated by local enable
    cur_req = "R5";
    wreg(3'd1, 16'h0200);
    drive(12'h001, 1'b0, 1'b0, 3'd2, 16'h0);
    idle(2);
    peek("R5", 3'd2, 16'h0000);
    drive(12'h200, 1'b0, 1'b0, 3'd2, 16'h0);
    idle(2);
    peek("R5", 3'd2, 16'h0001);
    chk("R8", {15'h0, irq}, 16'h0);

    // R8: signal mask gates the line
    cur_req = "R8";
    wreg(3'd4, 16'h0001);
    idle(1);
    chk("R8", {15'h0, irq}, 16'h1);

    // R7: clear while source still active, then real clear
    cur_req = "R7";
    wreg(3'd2, 16'h0001);
    idle(1);
    peek("R7", 3'd2, 16'h0001);
    wreg(3'd0, 16'h0201);
    wreg(3'd2, 16'h0001);
    idle(2);
    peek("R7", 3'd2, 16'h0000);
    chk("R7", {15'h0, irq}, 16'h0);

    // R4: event and clear in the same cycle
    cur_req = "R4";
    drive(12'h400, 1'b0, 1'b1, 3'd0, 16'h0400);
    peek("R4", 3'd0, 16'h0400);
    wreg(3'd0, 16'h0400);
    peek("R4", 3'd0, 16'h0000);

    // R6: peer bit gated by status-enable
    cur_req = "R6";
    wreg(3'd3, 16'h0001);
    drive(12'h0, 1'b1, 1'b0, 3'd2, 16'h0);
    idle(2);
    peek("R6", 3'd2, 16'h0000);
    wreg(3'd3, 16'h0003);
    wreg(3'd4, 16'h0002);
    drive(12'h0, 1'b1, 1'b0, 3'd2, 16'h0);
    idle(2);
    peek("R6", 3'd2, 16'h0002);
    chk("R8", {15'h0, irq}, 16'h1);
    drive(12'h0, 1'b1, 1'b1, 3'd2, 16'h0002);
    peek("R4", 3'd2, 16'h0002);
    wreg(3'd2, 16'h0002);
    idle(2);
    peek("R6", 3'd2, 16'h0000);
    chk("R8", {15'h0, irq}, 16'h0);

    // R9: map and unused addresses
    cur_req = "R9";
    peek("R9", 3'd4, 16'h0002);
    peek("R9", 3'd5, 16'h0000);
    peek("R9", 3'd7, 16'h0000);

    // mixed random traffic, compared every cycle
    cur_req = "R7";
    for (int n = 0; n < 600; n++) begin
      logic [11:0] ev;
      ev = (($urandom % 4) == 0) ? 12'(1 << ($urandom % 12)) : 12'h0;
      drive(ev, ($urandom % 6) == 0, ($urandom % 3) == 0,
            3'($urandom % 8), 16'($urandom));
    end
    idle(3);
    finish_run();
  end
endmodule